// File: doc/BRIEF.md
# Streaming Matrix Multiply Engine

This block computes elements of a matrix product C = A × B as dot products of one row of A with rows of the transposed B operand. Because B arrives transposed, both operands of a dot product are read at the same index. The engine drives one read index per cycle into external single-cycle-latency buffers for A and B and receives one operand pair per cycle. It multiplies each pair in an eight-stage pipeline and sums the products into an accumulator. Each finished element goes out on a write port toward the C buffer.

B storage has two banks. Each bank holds one transposed-B row, so each bank yields one C element. While the engine reads one bank, an external controller refills the other. The two sides coordinate through messages. When a bank's last element has been read, the engine posts a bank-done message. It reads that bank again only after a bank-ready message for it comes back. A running checksum of every C element written in the job is posted as a final message. A job is started by a pulse that captures the row length (1 to 2^AW) and the number of output elements (1 to 2^CW).

Top module: `mmul_stream_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `rd_en`, `c_we` and `msg_out_valid` are low.
- R2: Each written element equals the sum over k < row_len of A[k]·Bt_j[k], computed in 32-bit two's complement with wraparound. C index j holds the element built from the j-th bank fill of the job.
- R3: Within a job, read indices run 0 to row_len-1 with `rd_idx` shared by A and B, one index per cycle. There is no gap inside a bank, and no read occurs once every element of the job has been issued.
- R4: With row_len = 1, each element equals its single product: the accumulator restarts at the first product of every element.
- R5: The first read of every job uses bank 0. Later elements alternate banks 0, 1, 0, …
- R6: One cycle after a bank's last index is read, a message with kind 2'b01 (bank done) is posted. Its data holds the bank number in bit 0.
- R7: A bank is read only after a bank-ready input (`msg_in_valid` with `msg_in_bank`) has marked it, and never again after its bank-done message until it is marked again. If the bank is not marked, the engine stalls.
- R8: An element's C write is visible exactly 10 cycles after the cycle in which its last index was read.
- R9: One cycle after the job's last C write, a message of kind 2'b10 carries the 32-bit wrapped sum of all C elements of the job. `busy` is low in that same cycle.
- R10: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Job start pulse, taken only when idle |
| row_len | input | AW+1 | Dot-product length, 1..2^AW |
| col_count | input | CW+1 | Elements in the job, 1..2^CW |
| busy | output | 1 | Job in progress |
| rd_en | output | 1 | Operand read this cycle |
| rd_idx | output | AW | Shared A/B read index |
| rd_bank | output | 1 | B bank being read |
| a_rdata | input | DW | A data, one cycle after the read |
| b_rdata | input | DW | B data, one cycle after the read |
| c_we | output | 1 | C element write strobe |
| c_addr | output | CW | C element index |
| c_wdata | output | DW | C element value |
| msg_in_valid | input | 1 | Bank-ready message strobe |
| msg_in_bank | input | 1 | Bank named by the ready message |
| msg_out_valid | output | 1 | Outgoing message strobe |
| msg_out_kind | output | 2 | 01 bank done, 10 checksum |
| msg_out_data | output | DW | Bank number or checksum |

## Verification
A bank-done message is due one cycle after the read of a bank's last index. A C write is due ten cycles after that read: one for the buffer read, eight for the multiplier, one for the accumulator. The checksum message and the drop of `busy` follow the final C write by one cycle. The bench samples every output at the falling edge and timestamps each last-index read with a cycle counter. It then checks that each message and write appears in exactly the due cycle, not just eventually. A bench controller refills banks after random delays, so stalls and back-to-back elements both occur.

// File: rtl/mmul_pkg.sv
// Shared definitions for the streaming matrix multiply engine.
// Assumes two B banks; message kind codes are seen by the external controller.
package mmul_pkg;
    localparam int NBANK = 2;
    localparam logic [1:0] MSG_BANK_DONE = 2'b01;
    localparam logic [1:0] MSG_CHECKSUM  = 2'b10;

    // Per-operand-pair control travelling beside the data.
    typedef struct packed {
        logic fin;    // last pair of the last element of the job
        logic last;   // last pair of an element
        logic first;  // first pair of an element
        logic valid;  // pair present
    } op_tag_t;
endpackage

// File: rtl/mmul_issue.sv
// Read sequencer: walks row indices, alternates B banks, tracks bank-ready
// flags and posts bank-done events. Assumes row_len and col_count are nonzero.
module mmul_issue
    import mmul_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW:0]   row_len,
    input  logic [CW:0]   col_count,
    input  logic          msg_in_valid,
    input  logic          msg_in_bank,
    input  logic          job_fin,
    output logic          busy,
    output logic          rd_en,
    output logic [AW-1:0] rd_idx,
    output logic          rd_bank,
    output logic          clr,
    output op_tag_t       tag_o,
    output logic [CW-1:0] tag_col_o,
    output logic          bdone_v,
    output logic          bdone_bank
);
    logic            busy_q, bank_q;
    logic [AW:0]     len_q;
    logic [CW:0]     cols_q, col_q;
    logic [AW-1:0]   idx_q;
    logic [NBANK-1:0] rdy_w;
    logic            row_end, final_col, issuing;

    assign issuing   = col_q < cols_q;
    assign row_end   = ({1'b0, idx_q} == len_q - 1'b1);
    assign final_col = (col_q == cols_q - 1'b1);
    assign rd_en     = busy_q && issuing && rdy_w[bank_q];
    assign clr       = start && !busy_q;
    assign busy      = busy_q;
    assign rd_idx    = idx_q;
    assign rd_bank   = bank_q;

    // One ready flag per bank: set by a ready message, cleared when drained.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (msg_in_valid && msg_in_bank == 1'(b))
                flag_q <= 1'b1;
            else if (rd_en && row_end && bank_q == 1'(b))
                flag_q <= 1'b0;
        end
        assign rdy_w[b] = flag_q;
    end

    // Job capture, index walk, bank swap and bank-done event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            len_q      <= '0;
            cols_q     <= '0;
            idx_q      <= '0;
            col_q      <= '0;
            bank_q     <= 1'b0;
            bdone_v    <= 1'b0;
            bdone_bank <= 1'b0;
        end else begin
            bdone_v <= 1'b0;
            if (clr) begin
                busy_q <= 1'b1;
                len_q  <= row_len;
                cols_q <= col_count;
                idx_q  <= '0;
                col_q  <= '0;
                bank_q <= 1'b0;
            end else if (rd_en) begin
                if (row_end) begin
                    idx_q      <= '0;
                    col_q      <= col_q + 1'b1;
                    bank_q     <= ~bank_q;
                    bdone_v    <= 1'b1;
                    bdone_bank <= bank_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (job_fin) busy_q <= 1'b0;
        end
    end

    // Tag register aligned with the one-cycle buffer read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o     <= '0;
            tag_col_o <= '0;
        end else begin
            tag_o     <= '{fin: rd_en && row_end && final_col, last: row_end,
                           first: (idx_q == '0), valid: rd_en};
            tag_col_o <= col_q[CW-1:0];
        end
    end

    // R3
    rd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !row_end) |=> (rd_en && rd_idx == $past(rd_idx) + 1'b1));
    // R5
    first_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_bank == 1'b0 && rd_idx == '0));
    // R7
    reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bdone_v |-> (!rdy_w[bdone_bank] ||
                     $past(msg_in_valid && msg_in_bank == bdone_bank)));
    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && !job_fin) |=> busy_q);
endmodule

// File: rtl/mmul_mul_pipe.sv
// Eight-stage (STAGES) multiply pipeline that accepts a pair every cycle.
// Stage 0 forms the low DW bits of the product (identical for signed and
// unsigned operands); later stages delay it with its tag and element index.
module mmul_mul_pipe
    import mmul_pkg::*;
#(
    parameter int DW     = 32,
    parameter int CW     = 4,
    parameter int STAGES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  op_tag_t       tag_i,
    input  logic [CW-1:0] col_i,
    output logic [DW-1:0] prod_o,
    output op_tag_t       tag_o,
    output logic [CW-1:0] col_o
);
    logic [DW-1:0] prod_q [STAGES];
    op_tag_t       tg_q   [STAGES];
    logic [CW-1:0] cl_q   [STAGES];

    // Multiply in stage 0, then shift data and control through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                prod_q[i] <= '0;
                tg_q[i]   <= '0;
                cl_q[i]   <= '0;
            end
        end else begin
            prod_q[0] <= a_i * b_i;
            tg_q[0]   <= tag_i;
            cl_q[0]   <= col_i;
            for (int i = 1; i < STAGES; i++) begin
                prod_q[i] <= prod_q[i-1];
                tg_q[i]   <= tg_q[i-1];
                cl_q[i]   <= cl_q[i-1];
            end
        end
    end

    assign prod_o = prod_q[STAGES-1];
    assign tag_o  = tg_q[STAGES-1];
    assign col_o  = cl_q[STAGES-1];
endmodule

// File: rtl/mmul_accum.sv
// Accumulator, C write port and job checksum. Restarts the sum on a tagged
// first product, writes on a tagged last product, and raises the checksum
// event one cycle after the final write. Assumes clr only arrives when idle.
module mmul_accum
    import mmul_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  op_tag_t       tag_i,
    input  logic [CW-1:0] col_i,
    input  logic [DW-1:0] prod_i,
    output logic          c_we,
    output logic [CW-1:0] c_addr,
    output logic [DW-1:0] c_wdata,
    output logic          sum_v,
    output logic [DW-1:0] sum_data,
    output logic          job_fin
);
    logic [DW-1:0] acc_q, chk_q, sum_now;
    logic          fin_q;

    assign sum_now  = tag_i.first ? prod_i : acc_q + prod_i;
    assign sum_data = chk_q;
    assign job_fin  = fin_q;

    // Accumulate products, emit finished elements, fold them into the checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            chk_q   <= '0;
            c_we    <= 1'b0;
            c_addr  <= '0;
            c_wdata <= '0;
            fin_q   <= 1'b0;
            sum_v   <= 1'b0;
        end else begin
            c_we  <= 1'b0;
            fin_q <= 1'b0;
            sum_v <= fin_q;
            if (clr) chk_q <= '0;
            if (tag_i.valid) begin
                acc_q <= sum_now;
                if (tag_i.last) begin
                    c_we    <= 1'b1;
                    c_addr  <= col_i;
                    c_wdata <= sum_now;
                    chk_q   <= chk_q + sum_now;
                    fin_q   <= tag_i.fin;
                end
            end
        end
    end

    // R2
    write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> $past(tag_i.valid && tag_i.last));
    // R4
    first_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i.valid && tag_i.first && tag_i.last) |=> (c_we && c_wdata == $past(prod_i)));
    // R9
    sum_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_v |-> $past(c_we));
endmodule

// File: rtl/mmul_stream_engine.sv
// Top of the streaming matrix multiply engine: sequencer, multiply pipeline
// and accumulator, plus the outgoing message mux. Assumes external A and B
// buffers return data one cycle after rd_idx/rd_bank are presented.
module mmul_stream_engine
    import mmul_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter int CW     = 4,
    parameter int STAGES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW:0]   row_len,
    input  logic [CW:0]   col_count,
    output logic          busy,
    output logic          rd_en,
    output logic [AW-1:0] rd_idx,
    output logic          rd_bank,
    input  logic [DW-1:0] a_rdata,
    input  logic [DW-1:0] b_rdata,
    output logic          c_we,
    output logic [CW-1:0] c_addr,
    output logic [DW-1:0] c_wdata,
    input  logic          msg_in_valid,
    input  logic          msg_in_bank,
    output logic          msg_out_valid,
    output logic [1:0]    msg_out_kind,
    output logic [DW-1:0] msg_out_data
);
    op_tag_t       iss_tag, mul_tag;
    logic [CW-1:0] iss_col, mul_col;
    logic [DW-1:0] mul_prod, sum_data;
    logic          clr, job_fin, sum_v, bdone_v, bdone_bank;

    mmul_issue #(.AW(AW), .CW(CW)) issue_i (
        .clk(clk), .rst_n(rst_n), .start(start), .row_len(row_len),
        .col_count(col_count), .msg_in_valid(msg_in_valid),
        .msg_in_bank(msg_in_bank), .job_fin(job_fin), .busy(busy),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_bank(rd_bank), .clr(clr),
        .tag_o(iss_tag), .tag_col_o(iss_col), .bdone_v(bdone_v),
        .bdone_bank(bdone_bank));

    mmul_mul_pipe #(.DW(DW), .CW(CW), .STAGES(STAGES)) mul_i (
        .clk(clk), .rst_n(rst_n), .a_i(a_rdata), .b_i(b_rdata),
        .tag_i(iss_tag), .col_i(iss_col), .prod_o(mul_prod),
        .tag_o(mul_tag), .col_o(mul_col));

    mmul_accum #(.DW(DW), .CW(CW)) acc_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tag_i(mul_tag),
        .col_i(mul_col), .prod_i(mul_prod), .c_we(c_we), .c_addr(c_addr),
        .c_wdata(c_wdata), .sum_v(sum_v), .sum_data(sum_data),
        .job_fin(job_fin));

    // Merge the two message sources; they never coincide within a job.
    assign msg_out_valid = bdone_v | sum_v;
    assign msg_out_kind  = sum_v ? MSG_CHECKSUM : (bdone_v ? MSG_BANK_DONE : 2'b00);
    assign msg_out_data  = sum_v ? sum_data : {{(DW-1){1'b0}}, bdone_bank};

    // R6
    msg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bdone_v && sum_v));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !c_we && !msg_out_valid));
endmodule

// File: tb/mmul_stream_engine_tb.sv
// Self-checking bench: buffer models, a bank-refill controller with random
// delays, and cycle-exact checks of reads, writes and messages.
module mmul_stream_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32, AW = 4, CW = 4, LAT = 10, MAXN = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW:0] row_len = '0;
    logic [CW:0] col_count = '0;
    logic busy, rd_en, rd_bank, c_we, msg_out_valid;
    logic [AW-1:0] rd_idx;
    logic [CW-1:0] c_addr;
    logic [DW-1:0] a_rdata, b_rdata, c_wdata, msg_out_data;
    logic [1:0] msg_out_kind;
    logic msg_in_valid = 1'b0, msg_in_bank = 1'b0;

    mmul_stream_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .row_len(row_len),
        .col_count(col_count), .busy(busy), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_bank(rd_bank), .a_rdata(a_rdata), .b_rdata(b_rdata), .c_we(c_we),
        .c_addr(c_addr), .c_wdata(c_wdata), .msg_in_valid(msg_in_valid),
        .msg_in_bank(msg_in_bank), .msg_out_valid(msg_out_valid),
        .msg_out_kind(msg_out_kind), .msg_out_data(msg_out_data));

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [DW-1:0] amem [MAXN];
    logic [DW-1:0] bmem [2][MAXN];
    logic [DW-1:0] bt   [MAXN][MAXN];
    logic [DW-1:0] exp_c [MAXN];
    logic [DW-1:0] sum_exp;
    int cyc = 0;

    // Buffer models with one-cycle read latency, plus the cycle counter.
    always @(posedge clk) begin
        a_rdata <= amem[rd_idx];
        b_rdata <= bmem[rd_bank][rd_idx];
        cyc     <= cyc + 1;
    end

    int checks = 0, errors = 0;
    int len, ncols, exp_idx, exp_col, exp_bank, next_load, got_cnt, wr_cyc;
    int last_cyc [MAXN];
    int cnt [2];
    int lcol [2];
    bit pend [2];
    bit tr_rdy [2];
    bit prev_mid, job_end;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [DW-1:0] dot(input int j);
        logic [DW-1:0] s = '0;
        for (int k = 0; k < len; k++) s = s + amem[k] * bt[j][k];
        return s;
    endfunction

    task automatic load_bank(input int b, input int j);
        for (int k = 0; k < MAXN; k++) bmem[b][k] = bt[j][k];
    endtask

    // One falling edge: clear pulses, check outputs, run the refill controller.
    task automatic tick();
        bit sent = 0;
        @(negedge clk);
        msg_in_valid = 1'b0;
        start = 1'b0;
        if (msg_out_valid) begin
            check(msg_out_kind == 2'b01 || msg_out_kind == 2'b10, "R6", msg_out_kind, 1);
            if (msg_out_kind == 2'b01) begin
                // R6: bank done one cycle after the bank's last read
                check(exp_col >= 1 && msg_out_data == ((exp_col-1) % 2), "R6",
                      msg_out_data, (exp_col-1) % 2);
                check(exp_col >= 1 && last_cyc[(exp_col-1) % MAXN] == cyc-1, "R6",
                      cyc, last_cyc[(exp_col-1) % MAXN] + 1);
                tr_rdy[msg_out_data[0]] = 1'b0;
                if (next_load < ncols) begin
                    pend[msg_out_data[0]] = 1'b1;
                    cnt[msg_out_data[0]]  = $urandom_range(0, 4);
                    lcol[msg_out_data[0]] = next_load;
                    next_load++;
                end
            end else begin
                // R9: checksum one cycle after final write, busy low
                check(msg_out_data == sum_exp, "R9", msg_out_data, sum_exp);
                check(cyc == wr_cyc + 1, "R9", cyc, wr_cyc + 1);
                check(got_cnt == ncols, "R9", got_cnt, ncols);
                check(busy == 1'b0, "R9", busy, 0);
                job_end = 1'b1;
            end
        end
        if (rd_en) begin
            // R7: only marked banks are read
            check(tr_rdy[rd_bank], "R7", rd_bank, 1);
            // R3 / R5: index order and bank alternation from bank 0
            check(exp_col < ncols, "R3", exp_col, ncols);
            check(rd_idx == exp_idx[AW-1:0] && rd_bank == exp_bank[0], "R5",
                  {27'd0, rd_bank, rd_idx}, exp_bank * MAXN + exp_idx);
            if (exp_idx == len - 1) begin
                last_cyc[exp_col % MAXN] = cyc;
                exp_idx = 0; exp_bank ^= 1; exp_col++; prev_mid = 0;
            end else begin
                exp_idx++; prev_mid = 1;
            end
        end else begin
            if (prev_mid) check(1'b0, "R3", 0, 1);
            prev_mid = 0;
        end
        if (c_we) begin
            check(c_wdata == exp_c[c_addr], (len == 1) ? "R4" : "R2", c_wdata, exp_c[c_addr]);
            // R8: write ten cycles after the last read of the element
            check(cyc - last_cyc[c_addr] == LAT, "R8", cyc - last_cyc[c_addr], LAT);
            got_cnt++;
            wr_cyc = cyc;
        end
        for (int b = 0; b < 2; b++) begin
            if (pend[b]) begin
                if (cnt[b] > 0) cnt[b]--;
                else if (!sent) begin
                    load_bank(b, lcol[b]);
                    msg_in_valid = 1'b1; msg_in_bank = b[0];
                    tr_rdy[b] = 1'b1; pend[b] = 1'b0; sent = 1;
                end
            end
        end
    endtask

    task automatic run_job(input int l, input int nc, input int mode);
        int guard = 0;
        len = l; ncols = nc;
        for (int k = 0; k < MAXN; k++) begin
            amem[k] = (mode == 1) ? 32'h7fff_ffff : $urandom();
            for (int j = 0; j < MAXN; j++) bt[j][k] = (mode == 1) ? 32'h8000_0001 : $urandom();
        end
        sum_exp = '0;
        for (int j = 0; j < MAXN; j++) begin
            exp_c[j] = dot(j);
            if (j < nc) sum_exp = sum_exp + exp_c[j];
            last_cyc[j] = -100;
        end
        exp_idx = 0; exp_col = 0; exp_bank = 0; got_cnt = 0; wr_cyc = -100;
        prev_mid = 0; job_end = 0; pend[0] = 0; pend[1] = 0;
        tick();
        load_bank(0, 0); msg_in_valid = 1'b1; msg_in_bank = 1'b0; tr_rdy[0] = 1'b1;
        if (nc > 1) begin
            tick();
            load_bank(1, 1); msg_in_valid = 1'b1; msg_in_bank = 1'b1; tr_rdy[1] = 1'b1;
        end
        next_load = (nc > 1) ? 2 : 1;
        tick();
        start = 1'b1; row_len = l[AW:0]; col_count = nc[CW:0];
        tick();
        // R10: a second start while busy must not restart the walk
        start = 1'b1; row_len = 5'd1; col_count = 5'd1;
        while (!job_end && guard < 5000) begin
            tick();
            guard++;
        end
        if (!job_end) check(1'b0, "watchdog", guard, 5000);
        check(got_cnt == nc, "R10", got_cnt, nc);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        tr_rdy[0] = 0; tr_rdy[1] = 0; len = 1; ncols = 0;
        for (int k = 0; k < MAXN; k++) begin
            amem[k] = '0; bmem[0][k] = '0; bmem[1][k] = '0;
        end
        for (int i = 0; i < 3; i++) begin
            tick();
            // R1: quiet outputs during reset
            check(!busy && !rd_en && !c_we && !msg_out_valid, "R1",
                  {busy, rd_en, c_we, msg_out_valid}, 0);
        end
        rst_n = 1'b1;
        tick();
        check(!busy && !rd_en && !c_we && !msg_out_valid, "R1",
              {busy, rd_en, c_we, msg_out_valid}, 0);
        run_job(1, 3, 0);     // single-product elements
        run_job(16, 2, 1);    // full length, wrapping products
        run_job(16, 16, 0);   // largest job
        run_job(3, 1, 0);     // one element only
        for (int r = 0; r < 6; r++)
            run_job($urandom_range(1, 16), $urandom_range(1, 16), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule